// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This block performs one atomic memory update per request. On acceptance it reads the target word from memory. It keeps the memory locked while it combines the loaded value with the source operand. It writes the combined value back to the same address and then releases the lock. The instruction result is the value that memory held before the update. Nine operators are available: swap, add, AND, OR, XOR, and the signed and unsigned forms of maximum and minimum.

The datapath is 64 bits wide, and the operand size can be 64 bits (doubleword) or 32 bits (word). A word operation works on the 32-bit half of the doubleword that the address selects. Its compares look only at those 32 bits, and its result is sign-extended to 64 bits. A request whose address is not aligned to the operand size does no memory access and finishes at once with a fault. The two ordering hints that come with each request are carried to the memory side without change.

Top module: `amo_unit`

## Requirements
- R1: `req_op_i` selects the operator. The codes are 0 swap (new = src), 1 add, 2 AND, 3 OR, 4 XOR, 5 signed max, 6 signed min, 7 unsigned max and 8 unsigned min. Max and min write back the larger or smaller of the loaded value and the source.
- R2: `result_o` is valid while `done_o` is high. For a doubleword operation it equals the memory value from before the update.
- R3: For a word operation (`req_dword_i`=0), address bit 2 selects bytes 0-3 (0) or bytes 4-7 (1). Compares use only those 32 bits. Only those four bytes are written (`mem_wmask_o` is 8'h0F or 8'hF0). `result_o` is the old 32-bit value sign-extended.
- R4: A word address with bits [1:0] nonzero, or a doubleword address with bits [2:0] nonzero, is misaligned. Such a request raises no read and no write. It raises `done_o` with `fault_o`=1 and `result_o`=0 in the cycle after acceptance.
- R5: The sequence is one `mem_rd_o` pulse, then `mem_rvalid_i`, then one `mem_wr_o` pulse, then `mem_wack_i`. `mem_lock_o` is high from the read pulse until the cycle in which the write is acknowledged, for any memory latency.
- R6: `mem_aq_o` and `mem_rl_o` equal the request's `req_aq_i` and `req_rl_i` while the lock is held.
- R7: `done_o` is high for exactly one cycle. A request is accepted only while `req_ready_o` is high (idle). Requests presented while busy are ignored.
- R8: After reset, `req_ready_o` is 1 and `done_o`, `mem_lock_o`, `mem_rd_o` and `mem_wr_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_op_i | input | 4 | Operator code |
| req_dword_i | input | 1 | 1 = 64-bit operand, 0 = 32-bit |
| req_addr_i | input | ADDR_W | Byte address |
| req_src_i | input | DATA_W | Source operand |
| req_aq_i | input | 1 | Acquire hint |
| req_rl_i | input | 1 | Release hint |
| req_ready_o | output | 1 | Idle, request can be accepted |
| done_o | output | 1 | Operation complete pulse |
| fault_o | output | 1 | Misalignment fault, valid with done_o |
| result_o | output | DATA_W | Pre-update memory value |
| mem_rd_o | output | 1 | Read request pulse |
| mem_wr_o | output | 1 | Write request pulse |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_wmask_o | output | DATA_W/8 | Byte write enables |
| mem_lock_o | output | 1 | Exclusive hold on memory |
| mem_aq_o | output | 1 | Acquire hint to memory |
| mem_rl_o | output | 1 | Release hint to memory |
| mem_rdata_i | input | DATA_W | Read data |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_wack_i | input | 1 | Write acknowledged |

## Verification
If the sequencer takes a wrong branch, the symptom appears at the ports within the operation. Possible symptoms are a lock that drops between the read and the write ack, a second read pulse, a done pulse wider than one cycle, or a done without any write. The bench checks these on every clock. A fault in the operator or lane logic does not show until the write ack. It appears as a wrong memory word, a wrong byte mask or a wrong result, and the bench compares all three against its own model at the done cycle. A corrupted stored address or operand size shows as a write to the wrong lane or a missing fault on misaligned addresses.

// File: rtl/amo_pkg.sv
package amo_pkg;
  typedef enum logic [3:0] {
    OP_SWAP = 4'd0,
    OP_ADD  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_MAX  = 4'd5,
    OP_MIN  = 4'd6,
    OP_MAXU = 4'd7,
    OP_MINU = 4'd8
  } amo_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_REQ, S_RD_WAIT, S_WR_REQ, S_WR_WAIT, S_DONE
  } amo_state_e;
endpackage

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [3:0]   op_i,
  input  logic         dword_i,
  input  logic [W-1:0] mem_i,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] new_o
);
  localparam int HW = W / 2;

  logic         is_signed;
  logic [W:0]   a_x, b_x;
  logic         a_lt_b;

  assign is_signed = (op_i == OP_MAX) || (op_i == OP_MIN);

  // widen to W+1 so one signed compare serves both signed and unsigned forms
  always_comb begin
    if (dword_i) begin
      a_x = {is_signed & mem_i[W-1], mem_i};
      b_x = {is_signed & src_i[W-1], src_i};
    end else begin
      a_x = {{(HW+1){is_signed & mem_i[HW-1]}}, mem_i[HW-1:0]};
      b_x = {{(HW+1){is_signed & src_i[HW-1]}}, src_i[HW-1:0]};
    end
  end

  assign a_lt_b = $signed(a_x) < $signed(b_x);

  always_comb begin
    unique case (op_i)
      OP_SWAP:         new_o = src_i;
      OP_ADD:          new_o = mem_i + src_i;
      OP_AND:          new_o = mem_i & src_i;
      OP_OR:           new_o = mem_i | src_i;
      OP_XOR:          new_o = mem_i ^ src_i;
      OP_MAX, OP_MAXU: new_o = a_lt_b ? src_i : mem_i;
      OP_MIN, OP_MINU: new_o = a_lt_b ? mem_i : src_i;
      default:         new_o = mem_i;
    endcase
  end
endmodule

// File: rtl/amo_seq.sv
module amo_seq
  import amo_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic misaligned_i,
  input  logic rvalid_i,
  input  logic wack_i,
  output logic ready_o,
  output logic rd_o,
  output logic wr_o,
  output logic lock_o,
  output logic capture_o,
  output logic done_o
);
  amo_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:    if (start_i) st_d = misaligned_i ? S_DONE : S_RD_REQ;
      S_RD_REQ:  st_d = S_RD_WAIT;
      S_RD_WAIT: if (rvalid_i) st_d = S_WR_REQ;
      S_WR_REQ:  st_d = S_WR_WAIT;
      S_WR_WAIT: if (wack_i) st_d = S_DONE;
      S_DONE:    st_d = S_IDLE;
      default:   st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= S_IDLE;
    else         st_q <= st_d;
  end

  assign ready_o   = (st_q == S_IDLE);
  assign rd_o      = (st_q == S_RD_REQ);
  assign wr_o      = (st_q == S_WR_REQ);
  assign lock_o    = (st_q == S_RD_REQ) || (st_q == S_RD_WAIT) ||
                     (st_q == S_WR_REQ) || (st_q == S_WR_WAIT);
  assign capture_o = (st_q == S_RD_WAIT) && rvalid_i;
  assign done_o    = (st_q == S_DONE);

  p_lock_span_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && !(st_q == S_WR_WAIT && wack_i)) |=> lock_o);
  p_req_locked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o || wr_o) |-> lock_o);
  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_read_before_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> $past(capture_o));
endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic [3:0]          req_op_i,
  input  logic                req_dword_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [DATA_W-1:0]   req_src_i,
  input  logic                req_aq_i,
  input  logic                req_rl_i,
  output logic                req_ready_o,
  output logic                done_o,
  output logic                fault_o,
  output logic [DATA_W-1:0]   result_o,
  output logic                mem_rd_o,
  output logic                mem_wr_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  output logic [DATA_W/8-1:0] mem_wmask_o,
  output logic                mem_lock_o,
  output logic                mem_aq_o,
  output logic                mem_rl_o,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  input  logic                mem_rvalid_i,
  input  logic                mem_wack_i
);
  localparam int HW    = DATA_W / 2;
  localparam int NB    = DATA_W / 8;
  localparam int OFF_W = $clog2(NB);

  logic                accept, misaligned, capture;
  logic [3:0]          op_q;
  logic                dword_q, aq_q, rl_q, fault_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   src_q, rdata_q, loaded, new_val;
  logic                hi_lane;

  assign misaligned = req_dword_i ? |req_addr_i[OFF_W-1:0] : |req_addr_i[OFF_W-2:0];
  assign accept     = req_valid_i && req_ready_o;

  amo_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (req_valid_i),
    .misaligned_i (misaligned),
    .rvalid_i     (mem_rvalid_i),
    .wack_i       (mem_wack_i),
    .ready_o      (req_ready_o),
    .rd_o         (mem_rd_o),
    .wr_o         (mem_wr_o),
    .lock_o       (mem_lock_o),
    .capture_o    (capture),
    .done_o       (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= '0;
      dword_q <= 1'b0;
      aq_q    <= 1'b0;
      rl_q    <= 1'b0;
      fault_q <= 1'b0;
      addr_q  <= '0;
      src_q   <= '0;
    end else if (accept) begin
      op_q    <= req_op_i;
      dword_q <= req_dword_i;
      aq_q    <= req_aq_i;
      rl_q    <= req_rl_i;
      fault_q <= misaligned;
      addr_q  <= req_addr_i;
      src_q   <= req_src_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (accept)  rdata_q <= '0;
    else if (capture) rdata_q <= mem_rdata_i;
  end

  assign hi_lane = addr_q[OFF_W-1];

  always_comb begin
    if (dword_q)      loaded = rdata_q;
    else if (hi_lane) loaded = {{HW{1'b0}}, rdata_q[DATA_W-1:HW]};
    else              loaded = {{HW{1'b0}}, rdata_q[HW-1:0]};
  end

  amo_alu #(.W(DATA_W)) u_alu (
    .op_i    (op_q),
    .dword_i (dword_q),
    .mem_i   (loaded),
    .src_i   (src_q),
    .new_o   (new_val)
  );

  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = dword_q ? new_val : {new_val[HW-1:0], new_val[HW-1:0]};
  assign mem_wmask_o = dword_q ? {NB{1'b1}} :
                       hi_lane ? {{(NB/2){1'b1}}, {(NB/2){1'b0}}} :
                                 {{(NB/2){1'b0}}, {(NB/2){1'b1}}};
  assign mem_aq_o    = mem_lock_o & aq_q;
  assign mem_rl_o    = mem_lock_o & rl_q;
  assign fault_o     = done_o & fault_q;
  assign result_o    = (!done_o || fault_q) ? '0 :
                       dword_q ? loaded : {{HW{loaded[HW-1]}}, loaded[HW-1:0]};

  p_wmask_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> $countones(mem_wmask_o) == (dword_q ? NB : NB/2));
  p_fault_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && misaligned) |=> (done_o && fault_o && !mem_rd_o));
  p_hint_pass_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_lock_o) |-> (mem_aq_o == $past(req_aq_i) && mem_rl_o == $past(req_rl_i)));
  p_idle_unlocked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_lock_o);
endmodule

// File: tb/amo_unit_tb.sv
module amo_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 64;
  localparam int AW = 32;

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic          req_valid_i = 1'b0, req_dword_i = 1'b0, req_aq_i = 1'b0, req_rl_i = 1'b0;
  logic [3:0]    req_op_i = '0;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_src_i = '0;
  logic          req_ready_o, done_o, fault_o, mem_rd_o, mem_wr_o, mem_lock_o, mem_aq_o, mem_rl_o;
  logic [DW-1:0] result_o, mem_wdata_o;
  logic [AW-1:0] mem_addr_o;
  logic [7:0]    mem_wmask_o;
  logic [DW-1:0] mem_rdata_i = '0;
  logic          mem_rvalid_i = 1'b0, mem_wack_i = 1'b0;

  amo_unit u_dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int checks = 0, errors = 0;
  logic [DW-1:0] mem [0:15];
  logic [DW-1:0] ref_mem [0:15];
  int lat = 1;
  int rd_cnt = 0, wr_cnt = 0, rd_seen = 0, wr_seen = 0;
  logic [AW-1:0] rd_a;
  logic exp_aq = 0, exp_rl = 0, in_seq = 0, prev_done = 0;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder
  always @(posedge clk_i) begin
    mem_rvalid_i <= 1'b0;
    mem_wack_i   <= 1'b0;
    if (mem_rd_o) begin
      rd_cnt <= lat; rd_a <= mem_addr_o;
    end else if (rd_cnt > 1) rd_cnt <= rd_cnt - 1;
    else if (rd_cnt == 1) begin
      rd_cnt <= 0; mem_rvalid_i <= 1'b1; mem_rdata_i <= mem[rd_a[6:3]];
    end
    if (mem_wr_o) begin
      for (int b = 0; b < 8; b++)
        if (mem_wmask_o[b]) mem[mem_addr_o[6:3]][8*b +: 8] <= mem_wdata_o[8*b +: 8];
      wr_cnt <= lat;
    end else if (wr_cnt > 1) wr_cnt <= wr_cnt - 1;
    else if (wr_cnt == 1) begin
      wr_cnt <= 0; mem_wack_i <= 1'b1;
    end
  end

  // per-clock monitor
  always @(negedge clk_i) if (rst_ni) begin
    if (mem_rd_o) begin
      rd_seen++; in_seq = 1;
      chk(mem_aq_o == exp_aq && mem_rl_o == exp_rl, "R6 hints", {mem_aq_o, mem_rl_o}, {exp_aq, exp_rl});
    end
    if (mem_wr_o) wr_seen++;
    if (in_seq) chk(mem_lock_o, "R5 lock held", mem_lock_o, 1);
    if (mem_wack_i) in_seq = 0;
    if (done_o) chk(!prev_done, "R7 done width", prev_done, 0);
    prev_done = done_o;
  end

  function automatic logic [DW-1:0] ref_op(int op, logic [DW-1:0] a, logic [DW-1:0] b, bit dw);
    longint sa, sb;
    logic [DW-1:0] ua, ub, r;
    if (dw) begin sa = a; sb = b; ua = a; ub = b; end
    else begin
      sa = {{32{a[31]}}, a[31:0]}; sb = {{32{b[31]}}, b[31:0]};
      ua = {32'b0, a[31:0]}; ub = {32'b0, b[31:0]};
    end
    case (op)
      0: r = b;
      1: r = a + b;
      2: r = a & b;
      3: r = a | b;
      4: r = a ^ b;
      5: r = (sa > sb) ? a : b;
      6: r = (sa < sb) ? a : b;
      7: r = (ua > ub) ? a : b;
      default: r = (ua < ub) ? a : b;
    endcase
    return r;
  endfunction

  task automatic run_op(input int op, input bit dw, input logic [AW-1:0] addr,
                        input logic [DW-1:0] src, input bit aq, input bit rl, input bit spam);
    int idx = int'(addr[6:3]);
    bit mis = dw ? (addr[2:0] != 0) : (addr[1:0] != 0);
    logic [DW-1:0] old = ref_mem[idx];
    logic [DW-1:0] a, nv, exp_res, exp_mem;
    int wait_n = 0;
    a = dw ? old : (addr[2] ? {32'b0, old[63:32]} : {32'b0, old[31:0]});
    nv = ref_op(op, a, src, dw);
    exp_mem = old;
    if (!mis) begin
      if (dw) exp_mem = nv;
      else if (addr[2]) exp_mem[63:32] = nv[31:0];
      else exp_mem[31:0] = nv[31:0];
    end
    exp_res = mis ? '0 : (dw ? old : {{32{a[31]}}, a[31:0]});
    exp_aq = aq; exp_rl = rl;
    rd_seen = 0; wr_seen = 0;
    @(negedge clk_i);
    req_valid_i = 1; req_op_i = 4'(op); req_dword_i = dw; req_addr_i = addr;
    req_src_i = src; req_aq_i = aq; req_rl_i = rl;
    @(negedge clk_i);
    if (spam) begin
      req_op_i = 4'd0; req_src_i = 64'hDEAD_BEEF_0BAD_F00D; req_aq_i = !aq; req_rl_i = !rl;
    end else req_valid_i = 0;
    while (!done_o && wait_n < 200) begin @(negedge clk_i); wait_n++; end
    req_valid_i = 0;
    chk(done_o, "R7 done seen", done_o, 1);
    chk(fault_o == mis, "R4 fault flag", fault_o, mis);
    chk(result_o == exp_res, dw ? "R2 result" : "R3 word result", result_o, exp_res);
    chk(mem[idx] == exp_mem, mis ? "R4 memory untouched" : (dw ? "R1 memory" : "R3 lane write"), mem[idx], exp_mem);
    chk(rd_seen == (mis ? 0 : 1) && wr_seen == (mis ? 0 : 1), "R5 one read one write",
        64'(rd_seen * 16 + wr_seen), mis ? 64'd0 : 64'd17);
    if (mis) chk(wait_n == 0, "R4 done next cycle", 64'(wait_n), 0);
    ref_mem[idx] = exp_mem;
    @(negedge clk_i);
    if (spam) begin
      chk(req_ready_o && rd_seen == (mis ? 0 : 1), "R7 busy request ignored", 64'(rd_seen), mis ? 0 : 1);
      chk(mem[idx] == exp_mem, "R7 memory after busy request", mem[idx], exp_mem);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    chk(0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i] = {32'(i * 32'h1111_0001), 32'(32'h8000_0000 - i * 32'h0100_0003)};
      ref_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk(req_ready_o && !done_o && !mem_lock_o && !mem_rd_o && !mem_wr_o, "R8 reset state",
        {req_ready_o, done_o, mem_lock_o, mem_rd_o, mem_wr_o}, 5'b10000);
    // R1 all operators, doubleword
    run_op(0, 1, 32'h08, 64'h0123_4567_89AB_CDEF, 0, 0, 0);
    run_op(1, 1, 32'h10, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0);
    run_op(2, 1, 32'h18, 64'hF0F0_F0F0_0F0F_0F0F, 1, 0, 0);
    run_op(3, 1, 32'h20, 64'h1000_0000_0000_0001, 0, 1, 0);
    run_op(4, 1, 32'h28, 64'hAAAA_5555_AAAA_5555, 1, 1, 0);
    run_op(5, 1, 32'h30, 64'h8000_0000_0000_0000, 0, 0, 0);
    run_op(6, 1, 32'h38, 64'h8000_0000_0000_0000, 0, 0, 0);
    run_op(7, 1, 32'h40, 64'h8000_0000_0000_0000, 0, 0, 0);
    run_op(8, 1, 32'h48, 64'h8000_0000_0000_0000, 0, 0, 0);
    // R3 word lanes with sign-sensitive compares
    lat = 3;
    run_op(5, 0, 32'h50, 64'h0000_0000_7FFF_FFFF, 0, 0, 0);
    run_op(7, 0, 32'h54, 64'hFFFF_FFFF_0000_0001, 1, 0, 0);
    run_op(6, 0, 32'h58, 64'h0000_0000_8000_0001, 0, 1, 0);
    run_op(8, 0, 32'h5C, 64'h1234_5678_0000_0002, 0, 0, 0);
    run_op(1, 0, 32'h64, 64'h0000_0000_FFFF_FFFF, 0, 0, 0);
    run_op(0, 0, 32'h60, 64'h0000_0000_CAFE_F00D, 1, 1, 0);
    // R4 misaligned
    run_op(1, 0, 32'h12, 64'h1, 0, 0, 0);
    run_op(1, 1, 32'h14, 64'h1, 0, 0, 0);
    // R7 requests while busy are ignored
    lat = 2;
    run_op(1, 1, 32'h68, 64'h5, 1, 0, 1);
    lat = 1;
    run_op(4, 0, 32'h6C, 64'hFFFF_FFFF, 0, 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule